// File: doc/BRIEF.md
# Shadow RAM Segment Access Decoder

This block steers every memory access of the upper adapter and ROM area to one of two places. The area runs from C0000h to FFFFFh and is cut into eight 32 KB segments. For each access the block raises exactly one of two flags. One flag sends the access to internal DRAM. The other sends it to the external expansion/ROM bus.

Each segment has its own enable bit. Two global direction bits then say whether the reads of enabled segments, the writes, or both are served from internal DRAM. Because of this, a segment can be read from ROM on the external bus while its writes land in the DRAM copy. That is the usual sequence for copying a ROM into shadow RAM. Accesses outside the area are internal and ignore the shadow controls.

The block also reports whether the system BIOS segment is shadowed for reads and for writes. It turns a remap request bit into the amount of memory, in KB, to be moved to the top of memory. Everything is combinational. There is no data stream, so every pin is a plain level signal with no handshake.

Top module: `shadow_seg_router`

## Requirements
- R1: Segment i (i = 0..7) covers addresses C0000h + i×8000h through C0000h + i×8000h + 7FFFh. Its routing is governed only by `seg_enable[i]`.
- R2: A read (`acc_write` = 0) of an enabled segment goes internal (`to_internal` = 1) when `shadow_rd_en` = 1, and external (`to_external` = 1) when `shadow_rd_en` = 0. `shadow_wr_en` has no effect on it.
- R3: A write (`acc_write` = 1) of an enabled segment goes internal when `shadow_wr_en` = 1 and external when it is 0. `shadow_rd_en` has no effect on it.
- R4: An access to a segment whose enable bit is 0 goes external for both reads and writes, whatever the direction bits are.
- R5: An access below C0000h or at or above 100000h goes internal, whatever `seg_enable` and the direction bits are.
- R6: Exactly one of `to_internal` and `to_external` is 1 at all times.
- R7: `bios_rd_shadow` = `seg_enable[6]` AND `shadow_rd_en`, independent of the access address.
- R8: `bios_wr_shadow` = `seg_enable[6]` AND `shadow_wr_en`, independent of the access address.
- R9: `remap_kb` is 128 when `remap_req` = 1 and 0 when it is 0.
- R10: All outputs follow input changes within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | 24 | Byte address of the current access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| seg_enable | input | 8 | Per-segment shadow enable, bit i for segment i |
| shadow_rd_en | input | 1 | Serve reads of enabled segments from internal DRAM |
| shadow_wr_en | input | 1 | Serve writes of enabled segments to internal DRAM |
| remap_req | input | 1 | Request a 128 KB top-of-memory remap |
| to_internal | output | 1 | Access goes to internal DRAM |
| to_external | output | 1 | Access goes to the external expansion/ROM bus |
| bios_rd_shadow | output | 1 | BIOS segment is read-shadowed |
| bios_wr_shadow | output | 1 | BIOS segment is write-shadowed |
| remap_kb | output | 8 | KB remapped to the top of memory |

## Verification
An access to the BIOS segment depends on the same enable and direction bits as the BIOS status flags. So routing and status can change together from one input change. The bench changes the enable or direction bits while the address sits in segment 6, then checks both the route flags and both status flags in that same half cycle. Random stimulus also mixes addresses near the segment edges with all direction combinations. This catches the route flipping at a wrong boundary while the status stays correct.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  parameter int ADDR_W    = 24;
  parameter int NUM_SEG   = 8;
  parameter int SEG_SHIFT = 15;
  parameter int WIN_BASE  = 32'h000C_0000;
  parameter int BIOS_SEG  = 6;
  parameter int REMAP_KB  = 128;
  parameter int REMAP_W   = 8;

  typedef enum logic {
    ROUTE_EXT = 1'b0,
    ROUTE_INT = 1'b1
  } route_e;
endpackage

// File: rtl/shadow_win_decode.sv
module shadow_win_decode #(
  parameter int ADDR_W    = shadow_pkg::ADDR_W,
  parameter int NUM_SEG   = shadow_pkg::NUM_SEG,
  parameter int SEG_SHIFT = shadow_pkg::SEG_SHIFT,
  parameter int WIN_BASE  = shadow_pkg::WIN_BASE
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               in_win,
  output logic [NUM_SEG-1:0] seg_hit
);
  localparam int AW1       = ADDR_W + 1;
  localparam int SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam logic [AW1-1:0] BASE_X = AW1'(WIN_BASE);
  localparam logic [AW1-1:0] END_X  = BASE_X + (AW1'(NUM_SEG) << SEG_SHIFT);

  logic [AW1-1:0] addr_x;
  logic [AW1-1:0] offset;

  assign addr_x = {1'b0, addr};
  assign offset = addr_x - BASE_X;
  assign in_win = (addr_x >= BASE_X) && (addr_x < END_X);

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    assign seg_hit[i] = in_win &&
                        (offset[SEG_SHIFT +: SEG_IDX_W] == SEG_IDX_W'(i));
  end

  // A window address selects exactly one segment; others select none (R1)
  always_comb begin
    assert_seg_single_R1: assert (in_win ? ($countones(seg_hit) == 1) : (seg_hit == '0));
  end
endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel #(
  parameter int NUM_SEG = shadow_pkg::NUM_SEG
) (
  input  logic               in_win,
  input  logic [NUM_SEG-1:0] seg_hit,
  input  logic               acc_write,
  input  logic [NUM_SEG-1:0] seg_enable,
  input  logic               shadow_rd_en,
  input  logic               shadow_wr_en,
  output logic               to_internal,
  output logic               to_external
);
  import shadow_pkg::*;

  logic               dir_int;
  logic [NUM_SEG-1:0] seg_int;
  route_e             route;

  assign dir_int = acc_write ? shadow_wr_en : shadow_rd_en;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_grant
    assign seg_int[i] = seg_hit[i] & seg_enable[i] & dir_int;
  end

  assign route       = (!in_win || (|seg_int)) ? ROUTE_INT : ROUTE_EXT;
  assign to_internal = (route == ROUTE_INT);
  assign to_external = (route == ROUTE_EXT);

  always_comb begin
    // Disabled hit segment always goes out to the bus (R4)
    assert_disabled_ext_R4: assert (!(in_win && ((seg_hit & seg_enable) == '0)) || to_external);
    // Enabled segment with direction bit clear goes external (R2/R3)
    assert_dir_clear_ext_R2: assert (!(in_win && ((seg_hit & seg_enable) != '0) && !dir_int) || to_external);
  end
endmodule

// File: rtl/shadow_status.sv
module shadow_status #(
  parameter int NUM_SEG  = shadow_pkg::NUM_SEG,
  parameter int BIOS_SEG = shadow_pkg::BIOS_SEG,
  parameter int REMAP_KB = shadow_pkg::REMAP_KB,
  parameter int REMAP_W  = shadow_pkg::REMAP_W
) (
  input  logic [NUM_SEG-1:0] seg_enable,
  input  logic               shadow_rd_en,
  input  logic               shadow_wr_en,
  input  logic               remap_req,
  output logic               bios_rd_shadow,
  output logic               bios_wr_shadow,
  output logic [REMAP_W-1:0] remap_kb
);
  localparam logic [REMAP_W-1:0] REMAP_VAL = REMAP_W'(REMAP_KB);

  assign bios_rd_shadow = seg_enable[BIOS_SEG] & shadow_rd_en;
  assign bios_wr_shadow = seg_enable[BIOS_SEG] & shadow_wr_en;
  assign remap_kb       = remap_req ? REMAP_VAL : '0;

  always_comb begin
    assert_bios_rd_R7: assert (!bios_rd_shadow || (seg_enable[BIOS_SEG] && shadow_rd_en));
    assert_bios_wr_R8: assert (!bios_wr_shadow || (seg_enable[BIOS_SEG] && shadow_wr_en));
    assert_remap_R9:   assert ((remap_kb == '0) || (remap_kb == REMAP_VAL));
  end
endmodule

// File: rtl/shadow_seg_router.sv
module shadow_seg_router #(
  parameter int ADDR_W    = shadow_pkg::ADDR_W,
  parameter int NUM_SEG   = shadow_pkg::NUM_SEG,
  parameter int SEG_SHIFT = shadow_pkg::SEG_SHIFT,
  parameter int WIN_BASE  = shadow_pkg::WIN_BASE,
  parameter int BIOS_SEG  = shadow_pkg::BIOS_SEG,
  parameter int REMAP_KB  = shadow_pkg::REMAP_KB,
  parameter int REMAP_W   = shadow_pkg::REMAP_W
) (
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic [NUM_SEG-1:0] seg_enable,
  input  logic               shadow_rd_en,
  input  logic               shadow_wr_en,
  input  logic               remap_req,
  output logic               to_internal,
  output logic               to_external,
  output logic               bios_rd_shadow,
  output logic               bios_wr_shadow,
  output logic [REMAP_W-1:0] remap_kb
);
  logic               in_win;
  logic [NUM_SEG-1:0] seg_hit;

  shadow_win_decode #(
    .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .addr    (acc_addr),
    .in_win  (in_win),
    .seg_hit (seg_hit)
  );

  shadow_route_sel #(.NUM_SEG(NUM_SEG)) u_route (
    .in_win       (in_win),
    .seg_hit      (seg_hit),
    .acc_write    (acc_write),
    .seg_enable   (seg_enable),
    .shadow_rd_en (shadow_rd_en),
    .shadow_wr_en (shadow_wr_en),
    .to_internal  (to_internal),
    .to_external  (to_external)
  );

  shadow_status #(
    .NUM_SEG(NUM_SEG), .BIOS_SEG(BIOS_SEG), .REMAP_KB(REMAP_KB), .REMAP_W(REMAP_W)
  ) u_status (
    .seg_enable     (seg_enable),
    .shadow_rd_en   (shadow_rd_en),
    .shadow_wr_en   (shadow_wr_en),
    .remap_req      (remap_req),
    .bios_rd_shadow (bios_rd_shadow),
    .bios_wr_shadow (bios_wr_shadow),
    .remap_kb       (remap_kb)
  );

  always_comb begin
    assert_route_onehot_R6: assert (to_internal ^ to_external);
    assert_outside_int_R5:  assert (in_win || to_internal);
  end
endmodule

// File: tb/shadow_seg_router_tb.sv
module shadow_seg_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [7:0]  seg_enable = '0;
  logic        shadow_rd_en = 1'b0;
  logic        shadow_wr_en = 1'b0;
  logic        remap_req = 1'b0;
  logic        to_internal, to_external, bios_rd_shadow, bios_wr_shadow;
  logic [7:0]  remap_kb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shadow_seg_router dut_i (
    .acc_addr(acc_addr), .acc_write(acc_write), .seg_enable(seg_enable),
    .shadow_rd_en(shadow_rd_en), .shadow_wr_en(shadow_wr_en), .remap_req(remap_req),
    .to_internal(to_internal), .to_external(to_external),
    .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow), .remap_kb(remap_kb)
  );

  function automatic bit exp_int(input logic [23:0] a, input bit w, input logic [7:0] en,
                                 input bit rd, input bit wr);
    int seg;
    if (a < 24'h0C0000 || a >= 24'h100000) return 1'b1;
    seg = int'((a - 24'h0C0000) / 24'h8000);
    if (!en[seg]) return 1'b0;
    return w ? wr : rd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h w=%0b en=%h rd=%0b wr=%0b actual=%h expected=%h",
               req, acc_addr, acc_write, seg_enable, shadow_rd_en, shadow_wr_en, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit ei;
    ei = exp_int(acc_addr, acc_write, seg_enable, shadow_rd_en, shadow_wr_en);
    chk(req, {31'd0, to_internal}, {31'd0, ei});
    chk("R6", {31'd0, to_external}, {31'd0, !ei});
    chk("R7", {31'd0, bios_rd_shadow}, {31'd0, seg_enable[6] & shadow_rd_en});
    chk("R8", {31'd0, bios_wr_shadow}, {31'd0, seg_enable[6] & shadow_wr_en});
    chk("R9", {24'd0, remap_kb}, remap_req ? 32'd128 : 32'd0);
  endtask

  task automatic apply(input logic [23:0] a, input bit w, input logic [7:0] en,
                       input bit rd, input bit wr, input bit rm, input string req);
    @(negedge clk);
    acc_addr = a; acc_write = w; seg_enable = en;
    shadow_rd_en = rd; shadow_wr_en = wr; remap_req = rm;
    #1;
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    #1;
    check_all("R5_reset");
    rst_n = 1'b1;

    // R1 segment edges, only one segment enabled at a time
    for (int s = 0; s < 8; s++) begin
      apply(24'h0C0000 + 24'(s) * 24'h8000,          1'b0, 8'(1 << s), 1'b1, 1'b0, 1'b0, "R1_lo");
      apply(24'h0C0000 + 24'(s) * 24'h8000 + 24'h7FFF, 1'b0, 8'(1 << s), 1'b1, 1'b0, 1'b0, "R1_hi");
      apply(24'h0C0000 + 24'(s) * 24'h8000,          1'b0, ~8'(1 << s), 1'b1, 1'b1, 1'b0, "R1_other");
    end
    // R2 and R3: split direction on one segment
    apply(24'h0D1234, 1'b0, 8'h04, 1'b0, 1'b1, 1'b0, "R2_rd_ext");
    apply(24'h0D1234, 1'b1, 8'h04, 1'b0, 1'b1, 1'b0, "R3_wr_int");
    apply(24'h0D1234, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, "R2_rd_int");
    apply(24'h0D1234, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0, "R3_wr_ext");
    // R4 disabled segment, both directions on
    apply(24'h0FFFFF, 1'b1, 8'h7F, 1'b1, 1'b1, 1'b0, "R4_wr");
    apply(24'h0FFFFF, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, "R4_rd");
    // R5 outside window edges
    apply(24'h0BFFFF, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, "R5_below");
    apply(24'h100000, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, "R5_above");
    apply(24'hFFFFFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R5_top");
    // R10 + BIOS segment: change enables mid-cycle, address in segment 6
    apply(24'h0F4000, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0, "R10_bios_a");
    #0.5;
    seg_enable = 8'h00; #0.5; check_all("R10_bios_b");
    shadow_wr_en = 1'b1; seg_enable = 8'h40; acc_write = 1'b1; #0.5; check_all("R10_bios_c");
    remap_req = 1'b1; #0.3; check_all("R10_remap");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      if ($urandom_range(0, 3) != 0)
        a = 24'h0C0000 + 24'($urandom_range(0, 32'h3FFFF));
      else
        a = 24'($urandom);
      apply(a, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            "R1_R2_R3_R4_R5_rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule